// File: doc/BRIEF.md
# Instruction Cycle Accountant with Pairing

This block charges retired instructions against a set of running cycle counters. Each valid pulse delivers one record. A record holds the raw cycle count, an opcode family index and an extra bus-penalty count that misaligned indexed addressing adds. The block converts the raw count into bus-aligned time, which is a multiple of 4. It then shifts that time right by a frequency divider setting. It adds the result to a main counter and to a global counter, and subtracts it from a signed interrupt countdown.

Some back-to-back instruction pairs finish their work in each other's misaligned bus slot, so together they cost 4 cycles less than when run separately. A writable permission table decides which (earlier family, later family) pairs may do this. When the count and penalty conditions are met, the later instruction gives back 2 cycles instead of being rounded up. A second, plain charge path rounds and accumulates a count without any pairing logic. It leaves the pairing history untouched.

Top module: `cycle_ledger`

## Requirements
- R1: After reset all three counters, the `paired` flag and `charge` read 0, the whole permission table reads 0, and the stored earlier count is 0, so the first instruction after reset never pairs.
- R2: A record with `rec_pair_en`=0 (plain path) charges its count rounded up to a multiple of 4. It ignores `rec_penalty` and `rec_family`, always reports `paired`=0, and leaves the stored earlier count and family unchanged.
- R3: A pairing-path record pairs only when three conditions all hold: the table bit for (stored earlier family, current family) is 1, the stored earlier count modulo 4 equals 2, and either the current count modulo 4 equals 2 or `rec_penalty` is nonzero.
- R4: Every pairing-path record stores its count plus its penalty as the new earlier count, and its family as the new earlier family.
- R5: A paired record whose count modulo 4 equals 2 is charged its count minus 2, with no rounding.
- R6: A record that pairs because of a nonzero penalty, with a count that is a multiple of 4, is charged its count unchanged.
- R7: An unpaired pairing-path record is charged its count plus its penalty, rounded up to a multiple of 4.
- R8: The charge is shifted right by `freq_shift` (0 to 3) before it is reported and accumulated.
- R9: Each record adds the shifted charge to `main_count` and to `global_count`, and subtracts it from `irq_countdown`. Idle cycles and table writes leave all three unchanged.
- R10: `paired` and `charge` update on the clock edge that samples `rec_valid`=1 and hold their values until the next record.
- R11: A table write with `tbl_we`=1 sets bit (`tbl_prev`, `tbl_cur`) to `tbl_bit` and takes effect for records from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | One record is presented this cycle |
| rec_pair_en | input | 1 | 1 = pairing path, 0 = plain charge path |
| rec_cycles | input | CYC_W | Raw instruction cycle count |
| rec_family | input | FAM_W | Opcode family index |
| rec_penalty | input | PEN_W | Extra bus-penalty cycles |
| freq_shift | input | 2 | Right shift applied to every charge |
| tbl_we | input | 1 | Permission table write enable |
| tbl_prev | input | FAM_W | Earlier-family index of the entry written |
| tbl_cur | input | FAM_W | Later-family index of the entry written |
| tbl_bit | input | 1 | Value written into the entry |
| paired | output | 1 | The last record paired with its predecessor |
| charge | output | CYC_W+1 | Shifted charge of the last record |
| main_count | output | CNT_W | Main cycle counter |
| global_count | output | CNT_W | Global clock counter |
| irq_countdown | output | CNT_W | Signed pending-interrupt countdown |

## Verification
The checker watches several rules on every cycle. Each counter moves by exactly the reported charge after a record and stays still otherwise. `paired` and `charge` hold between records, a plain-path record never reports a pairing, and a pairing never appears without either a count of 2 modulo 4 or a penalty. The correct charge values, and which condition blocks a pairing, can only be shown by the bench's scenarios. These cover the permitted and forbidden pair, the penalty-driven pair, the history that folds the penalty into the stored count, the plain path slipped between two paired records, and frequency division.

// File: rtl/cycle_ledger.sv
module cycle_ledger #(
  parameter int FAMILIES = 16,
  parameter int CYC_W    = 8,
  parameter int PEN_W    = 3,
  parameter int CNT_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rec_valid,
  input  logic                         rec_pair_en,
  input  logic [CYC_W-1:0]             rec_cycles,
  input  logic [$clog2(FAMILIES)-1:0]  rec_family,
  input  logic [PEN_W-1:0]             rec_penalty,
  input  logic [1:0]                   freq_shift,
  input  logic                         tbl_we,
  input  logic [$clog2(FAMILIES)-1:0]  tbl_prev,
  input  logic [$clog2(FAMILIES)-1:0]  tbl_cur,
  input  logic                         tbl_bit,
  output logic                         paired,
  output logic [CYC_W:0]               charge,
  output logic [CNT_W-1:0]             main_count,
  output logic [CNT_W-1:0]             global_count,
  output logic [CNT_W-1:0]             irq_countdown
);
  localparam int FAM_W = $clog2(FAMILIES);
  localparam int SUM_W = CYC_W + 1;
  localparam int TBL_N = 1 << (2 * FAM_W);

  logic [TBL_N-1:0] perm;
  logic [SUM_W-1:0] prev_cnt;
  logic [FAM_W-1:0] prev_fam;

  function automatic logic [SUM_W-1:0] up4(input logic [SUM_W-1:0] x);
    logic [SUM_W-1:0] t;
    t = x + SUM_W'(3);
    return {t[SUM_W-1:2], 2'b00};
  endfunction

  wire [SUM_W-1:0] cyc_x   = SUM_W'(rec_cycles);
  wire [SUM_W-1:0] pen_x   = SUM_W'(rec_penalty);
  wire             cyc_m2  = rec_cycles[1:0] == 2'b10;
  wire             prev_m2 = prev_cnt[1:0] == 2'b10;
  wire             pen_any = |rec_penalty;
  wire             may_pair = rec_pair_en && perm[{prev_fam, rec_family}]
                              && prev_m2 && (cyc_m2 || pen_any);

  logic [SUM_W-1:0] full_charge;
  always_comb begin
    if (!rec_pair_en)  full_charge = up4(cyc_x);
    else if (may_pair) full_charge = cyc_m2 ? cyc_x - SUM_W'(2) : cyc_x;
    else               full_charge = up4(cyc_x + pen_x);
  end

  wire [SUM_W-1:0] scaled = full_charge >> freq_shift;
  wire [CNT_W-1:0] step   = CNT_W'(scaled);

  always_ff @(posedge clk) begin
    if (!rst_n) perm <= '0;
    else if (tbl_we) perm[{tbl_prev, tbl_cur}] <= tbl_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cnt      <= '0;
      prev_fam      <= '0;
      paired        <= 1'b0;
      charge        <= '0;
      main_count    <= '0;
      global_count  <= '0;
      irq_countdown <= '0;
    end else if (rec_valid) begin
      if (rec_pair_en) begin
        prev_cnt <= cyc_x + pen_x;
        prev_fam <= rec_family;
      end
      paired        <= may_pair;
      charge        <= scaled;
      main_count    <= main_count + step;
      global_count  <= global_count + step;
      irq_countdown <= irq_countdown - step;
    end
  end
endmodule

// File: rtl/cycle_ledger_chk.sv
module cycle_ledger_chk #(
  parameter int FAMILIES = 16,
  parameter int CYC_W    = 8,
  parameter int PEN_W    = 3,
  parameter int CNT_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rec_valid,
  input logic                        rec_pair_en,
  input logic [CYC_W-1:0]            rec_cycles,
  input logic [PEN_W-1:0]            rec_penalty,
  input logic                        tbl_we,
  input logic                        paired,
  input logic [CYC_W:0]              charge,
  input logic [CNT_W-1:0]            main_count,
  input logic [CNT_W-1:0]            global_count,
  input logic [CNT_W-1:0]            irq_countdown
);
  // R9
  main_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rec_valid) |-> main_count == $past(main_count) + CNT_W'(charge));

  // R9
  global_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rec_valid) |-> global_count == $past(global_count) + CNT_W'(charge));

  // R9
  countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rec_valid) |-> irq_countdown == $past(irq_countdown) - CNT_W'(charge));

  // R9
  idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> $stable(main_count) && $stable(irq_countdown));

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> $stable(paired) && $stable(charge));

  // R2
  plain_nopair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_pair_en |=> !paired);

  // R3
  pair_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_cycles[1:0] != 2'b10 && rec_penalty == '0 |=> !paired);

  // R11
  write_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we && !rec_valid |=> $stable(global_count));
endmodule

bind cycle_ledger cycle_ledger_chk #(
  .FAMILIES(FAMILIES), .CYC_W(CYC_W), .PEN_W(PEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_pair_en(rec_pair_en),
  .rec_cycles(rec_cycles), .rec_penalty(rec_penalty), .tbl_we(tbl_we),
  .paired(paired), .charge(charge), .main_count(main_count),
  .global_count(global_count), .irq_countdown(irq_countdown)
);

// File: tb/cycle_ledger_tb.sv
`timescale 1ns/1ps
module cycle_ledger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0, rec_pair_en = 1'b0;
  logic [7:0]  rec_cycles = '0;
  logic [3:0]  rec_family = '0;
  logic [2:0]  rec_penalty = '0;
  logic [1:0]  freq_shift = '0;
  logic        tbl_we = 1'b0, tbl_bit = 1'b0;
  logic [3:0]  tbl_prev = '0, tbl_cur = '0;
  logic        paired;
  logic [8:0]  charge;
  logic [31:0] main_count, global_count, irq_countdown;
  int total = 0, bad = 0;
  int exp_sum;

  always #2.5 clk = ~clk;

  cycle_ledger u_dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_pair_en(rec_pair_en),
    .rec_cycles(rec_cycles), .rec_family(rec_family), .rec_penalty(rec_penalty),
    .freq_shift(freq_shift), .tbl_we(tbl_we), .tbl_prev(tbl_prev),
    .tbl_cur(tbl_cur), .tbl_bit(tbl_bit), .paired(paired), .charge(charge),
    .main_count(main_count), .global_count(global_count),
    .irq_countdown(irq_countdown)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; freq_shift = 2'd0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    exp_sum = 0;
  endtask

  task automatic permit(input int p, input int c, input bit v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_prev = 4'(p); tbl_cur = 4'(c); tbl_bit = v;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic send(input bit pe, input int cyc, input int fam, input int pen,
                      input string req, input int exp_charge, input bit exp_pair);
    @(negedge clk);
    rec_valid = 1'b1; rec_pair_en = pe; rec_cycles = 8'(cyc);
    rec_family = 4'(fam); rec_penalty = 3'(pen);
    @(negedge clk);
    rec_valid = 1'b0; rec_penalty = '0;
    exp_sum += exp_charge;
    chk({req, " charge"}, int'(charge), exp_charge);
    chk({req, " paired"}, int'(paired), int'(exp_pair));
  endtask

  task automatic totals(input string req);
    chk({req, " main"}, int'(main_count), exp_sum);
    chk({req, " global"}, int'(global_count), exp_sum);
    chk({req, " countdown"}, int'($signed(irq_countdown)), -exp_sum);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 paired", int'(paired), 0);
    chk("R1 charge", int'(charge), 0);
    totals("R1");
    permit(0, 0, 1'b1);
    send(1, 14, 0, 0, "R1 first never pairs", 16, 0);
  endtask

  task automatic t_plain();
    do_reset();
    send(0, 10, 0, 0, "R2 plain round", 12, 0);
    send(0, 13, 7, 4, "R2 plain ignores penalty", 16, 0);
    send(0, 16, 0, 0, "R2 plain exact", 16, 0);
    totals("R9 plain");
  endtask

  task automatic t_pair_basic();
    do_reset();
    permit(3, 5, 1'b1);
    send(1, 14, 3, 0, "R7 lead", 16, 0);
    send(1, 14, 5, 2, "R5 paired 14+2", 12, 1);
    totals("R9 pair total 28");
  endtask

  task automatic t_no_perm();
    do_reset();
    permit(3, 5, 1'b1);
    send(1, 14, 3, 0, "R7 lead", 16, 0);
    send(1, 14, 6, 2, "R3 no permission", 16, 0);
    totals("R9 no-pair total 32");
    permit(3, 6, 1'b1);
    permit(3, 6, 1'b0);
    send(1, 14, 3, 0, "R11 cleared lead", 16, 0);
    send(1, 14, 6, 0, "R11 cleared entry", 16, 0);
  endtask

  task automatic t_pen_pair();
    do_reset();
    permit(3, 5, 1'b1);
    send(1, 14, 3, 0, "R7 lead", 16, 0);
    send(1, 24, 5, 4, "R6 penalty pair", 24, 1);
    totals("R9 total 40");
  endtask

  task automatic t_history();
    do_reset();
    permit(3, 5, 1'b1);
    permit(5, 3, 1'b1);
    send(1, 12, 3, 2, "R7 penalty rounded", 16, 0);
    send(1, 14, 5, 0, "R4 stored count has penalty", 12, 1);
    send(1, 16, 3, 0, "R3 current multiple of 4", 16, 0);
    send(1, 14, 5, 0, "R3 earlier multiple of 4", 16, 0);
  endtask

  task automatic t_plain_between();
    do_reset();
    permit(3, 5, 1'b1);
    send(1, 14, 3, 0, "R7 lead", 16, 0);
    send(0, 10, 0, 0, "R2 plain between", 12, 0);
    send(1, 14, 5, 0, "R2 history kept", 12, 1);
  endtask

  task automatic t_shift();
    do_reset();
    freq_shift = 2'd2;
    send(1, 10, 3, 0, "R8 shift 2", 3, 0);
    freq_shift = 2'd1;
    send(0, 30, 0, 0, "R8 shift 1", 16, 0);
    totals("R8 totals");
    freq_shift = 2'd0;
  endtask

  task automatic t_hold();
    do_reset();
    send(0, 22, 0, 0, "R10 charge", 24, 0);
    permit(1, 2, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10 held charge", int'(charge), 24);
    chk("R10 held paired", int'(paired), 0);
    totals("R11 write leaves counters");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_pair_basic();
    t_no_perm();
    t_pen_pair();
    t_history();
    t_plain_between();
    t_shift();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule